// File: doc/BRIEF.md
# Flash Memory Command Interpreter

This block stands between a CPU bus and a byte-wide flash array and gives that array a command set. A byte written on the bus is decoded as a command. Depending on the command, the block selects a status or identification view for later reads, arms a single program cycle, or starts an erase. While no view is active, reads return array data. Bus addresses are folded into a flat array offset in one of two ways, chosen by a mode input: a linear layout, or a layout in which only the upper half of each 64 KiB bank is mapped.

A program cycle can only clear bits: the new array byte is the old byte ANDed with the bus data. Erase is confirmed by a pair of bytes. It then runs as a loop that writes 0xFF to one array byte per clock, and a busy output stays high until the loop ends. The array sits on a simple port: a combinational read of the addressed byte and a write strobe that takes effect on the clock edge.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset `busy` is low and no view is active. A read returns `mem_rdata` for the folded offset of `bus_addr`.
- R2: With `hirom_mode`=1 the offset is `bus_addr[19:0]`. With `hirom_mode`=0 it is `{bus_addr[20:16], bus_addr[14:0]}`. Both are truncated to ARRAY_AW bits.
- R3: A command byte of 0x00 or 0xFF clears every view and disarms programming. Reads then return array data.
- R4: Command 0x70 selects the compatible-status view. The next read returns 0x80 and ends the view, so the read after it returns array data.
- R5: Command 0x71 selects the extended-status view. Offsets (`bus_addr[15:0]`) 0x0002 and 0x8002 read 0xC0, and 0x0004 and 0x8004 read 0x82. Other offsets read the array.
- R6: Command 0x75 selects the identification view and ends the compatible-status view. A read at an even offset 0xFF00..0xFF12 returns byte (offset-0xFF00) of a 20-byte table. In that table byte 0 is 0x4D, byte 2 is 0x50, byte 6 is ID_TYPE, and every other byte is 0x00. Odd offsets read the array.
- R7: Command 0x50 ends the compatible-status and extended-status views and leaves the identification view as it was.
- R8: Command 0x10 or 0x40 arms one program cycle and the compatible-status view. The next write stores (old byte AND data) at its folded offset and is not decoded. The write after that is decoded as a command again.
- R9: 0xD0 written directly after 0x20 sets to 0xFF every byte of the 2^BLOCK_AW-byte block that holds the folded offset. 0xD0 after any other byte starts no erase.
- R10: An erase holds `busy` high for exactly one clock per erased byte and writes one byte per clock. Bus writes during `busy` are ignored, and reads during `busy` return 0x00 and consume nothing.
- R11: 0xD0 written directly after 0xA7 erases the whole array, but only when ID_TYPE[7:4] is 1 or 4. Otherwise it does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hirom_mode | input | 1 | 1 selects linear folding, 0 selects half-bank folding |
| bus_addr | input | 24 | CPU bus address |
| bus_wr | input | 1 | Bus write strobe, one cycle per byte |
| bus_rd | input | 1 | Bus read strobe, one cycle per byte |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (combinational) |
| busy | output | 1 | High while an erase loop runs |
| mem_addr | output | ARRAY_AW | Array byte offset |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array byte at `mem_addr` |

## Verification
A view flag stuck on or off appears at the very next bus read as a status constant in place of array data, or the reverse. A missing consume of the compatible-status view shows up as a second 0x80 on the read after that. A wrong byte in the command history reveals itself through erases that never start or that start by mistake, and this is visible on `busy` one clock after the confirming write. Errors in the erase counter or its bounds show up as a wrong busy length, or as 0xFF found just outside the erased block, on reads made once `busy` falls.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_RST_A = 8'h00;
  localparam logic [7:0] CMD_RST_B = 8'hFF;
  localparam logic [7:0] CMD_PGM_A = 8'h10;
  localparam logic [7:0] CMD_PGM_B = 8'h40;
  localparam logic [7:0] CMD_CLR   = 8'h50;
  localparam logic [7:0] CMD_CST   = 8'h70;
  localparam logic [7:0] CMD_EXT   = 8'h71;
  localparam logic [7:0] CMD_IDV   = 8'h75;
  localparam logic [7:0] CMD_GO    = 8'hD0;
  localparam logic [7:0] CMD_BLK   = 8'h20;
  localparam logic [7:0] CMD_CHIP  = 8'hA7;

  // field order: ext, cst, ident, prog
  typedef struct packed {
    logic ext;
    logic cst;
    logic ident;
    logic prog;
  } view_t;

  function automatic logic [7:0] id_byte(input logic [4:0] idx, input logic [7:0] type_b);
    case (idx)
      5'd0:    id_byte = 8'h4D;
      5'd2:    id_byte = 8'h50;
      5'd6:    id_byte = type_b;
      default: id_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/flash_addr_fold.sv
module flash_addr_fold #(
  parameter int ARRAY_AW = 20
) (
  input  logic [23:0]         bus_addr,
  input  logic                hirom_mode,
  output logic [ARRAY_AW-1:0] ofs
);
  logic [20:0] lin_ofs;
  logic [20:0] half_ofs;

  assign lin_ofs  = {1'b0, bus_addr[19:0]};
  assign half_ofs = {1'b0, bus_addr[20:16], bus_addr[14:0]};

  always_comb begin
    if (hirom_mode) ofs = lin_ofs[ARRAY_AW-1:0];
    else            ofs = half_ofs[ARRAY_AW-1:0];
  end
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter bit CHIP_OK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_take,
  input  logic       rd_take,
  input  logic [7:0] wdata,
  output view_t      view,
  output logic       prog_hit,
  output logic       blk_go,
  output logic       chip_go
);
  logic [7:0] prev_q, prev_d;
  logic       prev_en;
  view_t      view_d;

  always_comb begin
    view_d   = view;
    prev_d   = prev_q;
    prev_en  = 1'b0;
    blk_go   = 1'b0;
    chip_go  = 1'b0;
    prog_hit = wr_take & view.prog;
    if (rd_take && view.cst) view_d.cst = 1'b0;
    if (prog_hit) begin
      view_d.prog = 1'b0;
    end else if (wr_take) begin
      prev_en = 1'b1;
      prev_d  = wdata;
      case (wdata)
        CMD_RST_A, CMD_RST_B: view_d = '0;
        CMD_PGM_A, CMD_PGM_B: view_d = '{1'b0, 1'b1, 1'b0, 1'b1};
        CMD_CLR: begin
          view_d.ext = 1'b0;
          view_d.cst = 1'b0;
        end
        CMD_CST: view_d = '{1'b0, 1'b1, 1'b0, 1'b0};
        CMD_EXT: view_d = '{1'b1, 1'b0, 1'b0, 1'b0};
        CMD_IDV: begin
          view_d.cst   = 1'b0;
          view_d.ident = 1'b1;
        end
        CMD_GO: begin
          blk_go  = (prev_q == CMD_BLK);
          chip_go = (prev_q == CMD_CHIP) && CHIP_OK;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      view   <= '0;
      prev_q <= '0;
    end else begin
      view <= view_d;
      if (prev_en) prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int ARRAY_AW = 20,
  parameter int BLOCK_AW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blk_go,
  input  logic                chip_go,
  input  logic [ARRAY_AW-1:0] base,
  output logic                busy,
  output logic [ARRAY_AW-1:0] addr
);
  localparam int HI_W = ARRAY_AW - BLOCK_AW;

  logic [ARRAY_AW-1:0] cnt_d, last_q, last_d;
  logic [HI_W-1:0]     blk_sel;
  logic                busy_d, step_en;

  assign blk_sel = base[ARRAY_AW-1:BLOCK_AW];
  assign step_en = busy | blk_go | chip_go;

  always_comb begin
    busy_d = busy;
    cnt_d  = addr;
    last_d = last_q;
    if (busy) begin
      if (addr == last_q) busy_d = 1'b0;
      else                cnt_d  = addr + 1'b1;
    end else if (chip_go) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      last_d = '1;
    end else if (blk_go) begin
      busy_d = 1'b1;
      cnt_d  = {blk_sel, {BLOCK_AW{1'b0}}};
      last_d = {blk_sel, {BLOCK_AW{1'b1}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      addr   <= '0;
      last_q <= '0;
    end else if (step_en) begin
      busy   <= busy_d;
      addr   <= cnt_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         ARRAY_AW = 20,
  parameter int         BLOCK_AW = 16,
  parameter logic [7:0] ID_TYPE  = 8'h1A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hirom_mode,
  input  logic [23:0]         bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic                busy,
  output logic [ARRAY_AW-1:0] mem_addr,
  output logic                mem_we,
  output logic [7:0]          mem_wdata,
  input  logic [7:0]          mem_rdata
);
  localparam bit CHIP_OK = (ID_TYPE[7:4] == 4'h1) || (ID_TYPE[7:4] == 4'h4);

  logic [1:0]          rs_q;
  logic                rst_n_s;
  logic [ARRAY_AW-1:0] fold_ofs, ers_addr;
  logic                wr_take, rd_take, prog_hit, blk_go, chip_go;
  logic [15:0]         bofs;
  logic                id_hit;
  view_t               view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign wr_take = bus_wr & ~busy;
  assign rd_take = bus_rd & ~busy;

  flash_addr_fold #(.ARRAY_AW(ARRAY_AW)) u_fold (
    .bus_addr(bus_addr), .hirom_mode(hirom_mode), .ofs(fold_ofs)
  );

  flash_cmd_decode #(.CHIP_OK(CHIP_OK)) u_dec (
    .clk(clk), .rst_n(rst_n_s), .wr_take(wr_take), .rd_take(rd_take),
    .wdata(bus_wdata), .view(view), .prog_hit(prog_hit),
    .blk_go(blk_go), .chip_go(chip_go)
  );

  flash_erase_seq #(.ARRAY_AW(ARRAY_AW), .BLOCK_AW(BLOCK_AW)) u_ers (
    .clk(clk), .rst_n(rst_n_s), .blk_go(blk_go), .chip_go(chip_go),
    .base(fold_ofs), .busy(busy), .addr(ers_addr)
  );

  assign mem_addr  = busy ? ers_addr : fold_ofs;
  assign mem_we    = busy | prog_hit;
  assign mem_wdata = busy ? 8'hFF : (mem_rdata & bus_wdata);

  assign bofs   = bus_addr[15:0];
  assign id_hit = view.ident && (bofs[15:8] == 8'hFF) && !bofs[0] && (bofs[7:0] <= 8'h12);

  always_comb begin
    if (busy)                                             bus_rdata = 8'h00;
    else if (view.cst)                                    bus_rdata = 8'h80;
    else if (view.ext && (bofs == 16'h0002 || bofs == 16'h8002)) bus_rdata = 8'hC0;
    else if (view.ext && (bofs == 16'h0004 || bofs == 16'h8004)) bus_rdata = 8'h82;
    else if (id_hit)                                      bus_rdata = id_byte(bofs[4:0], ID_TYPE);
    else                                                  bus_rdata = mem_rdata;
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int ARRAY_AW = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [7:0]          bus_wdata,
  input logic                busy,
  input logic                mem_we,
  input logic [ARRAY_AW-1:0] mem_addr,
  input logic [7:0]          mem_wdata,
  input logic [7:0]          mem_rdata
);
  // R10
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_we && mem_wdata == 8'hFF));

  // R10
  erase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr == ARRAY_AW'($past(mem_addr) + 1'b1)));

  // R8
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !busy) |-> ((mem_wdata & ~mem_rdata) == 8'h00));

  // R8
  write_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy || bus_wr));

  // R9
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(bus_wr) && $past(bus_wdata) == 8'hD0));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ARRAY_AW(ARRAY_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
  localparam int AW  = 16;
  localparam int BW  = 8;
  localparam int AW2 = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hirom_mode = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata, mem_wdata, mem_rdata;
  logic        busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]  mem [0:(1<<AW)-1];

  logic [7:0]  l_rdata, l_wdata, l_rdata_in;
  logic        l_busy, l_we;
  logic [AW2-1:0] l_addr;
  logic [7:0]  mem2 [0:(1<<AW2)-1];

  int n_run = 0, n_fail = 0;
  logic lock_seen = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.ARRAY_AW(AW), .BLOCK_AW(BW), .ID_TYPE(8'h1A)) i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .hirom_mode(hirom_mode), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  flash_cmd_ctrl #(.ARRAY_AW(AW2), .BLOCK_AW(4), .ID_TYPE(8'h2A)) i_flash_cmd_ctrl_lock (
    .clk(clk), .rst_n(rst_n), .hirom_mode(hirom_mode), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(l_rdata),
    .busy(l_busy), .mem_addr(l_addr), .mem_we(l_we), .mem_wdata(l_wdata),
    .mem_rdata(l_rdata_in)
  );

  assign mem_rdata  = mem[mem_addr];
  assign l_rdata_in = mem2[l_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
  always @(posedge clk) if (l_we) mem2[l_addr] <= l_wdata;
  always @(negedge clk) if (l_busy) lock_seen <= 1'b1;

  function automatic logic [7:0] pat(input int i);
    logic [15:0] v;
    v = 16'(i);
    return v[7:0] ^ v[15:8] ^ 8'h96;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [23:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 busy after reset", 8'(busy), 8'h00);
    hirom_mode = 1'b0;
    do_rd(24'h00_8000, d);
    check("R1 normal read", d, pat(16'h0000));
  endtask

  task automatic t_fold;
    logic [7:0] d;
    hirom_mode = 1'b1;
    do_rd(24'h00_9234, d); check("R2 linear fold", d, pat(16'h9234));
    do_rd(24'h03_1234, d); check("R2 linear fold bank", d, pat(16'h1234));
    hirom_mode = 1'b0;
    do_rd(24'h01_1234, d); check("R2 half fold bank1", d, pat(16'h9234));
    do_rd(24'h00_9234, d); check("R2 half fold drops bit15", d, pat(16'h1234));
  endtask

  task automatic t_cst;
    logic [7:0] d;
    do_wr(24'h0, 8'h70);
    do_rd(24'h00_8010, d); check("R4 first read", d, 8'h80);
    do_rd(24'h00_8010, d); check("R4 view consumed", d, pat(16'h0010));
  endtask

  task automatic t_ext;
    logic [7:0] d;
    do_wr(24'h0, 8'h71);
    do_rd(24'h00_0002, d); check("R5 0002", d, 8'hC0);
    do_rd(24'h00_8004, d); check("R5 8004", d, 8'h82);
    do_rd(24'h00_8006, d); check("R5 other offset", d, pat(16'h0006));
  endtask

  task automatic t_id_clr;
    logic [7:0] d;
    do_wr(24'h0, 8'h75);
    do_rd(24'h00_FF00, d); check("R6 id byte0", d, 8'h4D);
    do_rd(24'h00_FF02, d); check("R6 id byte2", d, 8'h50);
    do_rd(24'h00_FF06, d); check("R6 id type", d, 8'h1A);
    do_rd(24'h00_FF12, d); check("R6 id last", d, 8'h00);
    do_rd(24'h00_FF01, d); check("R6 odd offset", d, pat(16'h7F01));
    do_rd(24'h00_0002, d); check("R6 ext kept", d, 8'hC0);
    do_wr(24'h0, 8'h50);
    do_rd(24'h00_8002, d); check("R7 ext cleared", d, pat(16'h0002));
    do_rd(24'h00_FF00, d); check("R7 id kept", d, 8'h4D);
    do_wr(24'h0, 8'hFF);
    do_rd(24'h00_FF00, d); check("R3 id cleared", d, pat(16'h7F00));
    do_wr(24'h0, 8'h70);
    do_wr(24'h0, 8'h00);
    do_rd(24'h00_8020, d); check("R3 cst cleared", d, pat(16'h0020));
  endtask

  task automatic t_prog;
    logic [7:0] d;
    hirom_mode = 1'b1;
    do_wr(24'h0, 8'h40);
    do_wr(24'h00_1234, 8'h3C);
    do_rd(24'h00_1234, d); check("R8 status after program", d, 8'h80);
    do_rd(24'h00_1234, d); check("R8 AND result", d, pat(16'h1234) & 8'h3C);
    do_wr(24'h0, 8'h10);
    do_wr(24'h00_1300, 8'hFF);
    do_wr(24'h00_1300, 8'h70);
    do_rd(24'h00_1300, d); check("R8 bits not set", d, 8'h80);
    do_rd(24'h00_1300, d); check("R8 rearmed decode", d, pat(16'h1300));
  endtask

  task automatic t_blk;
    logic [7:0] d;
    int n;
    hirom_mode = 1'b0;
    do_wr(24'h0, 8'hFF);
    do_wr(24'h0, 8'h70);
    do_wr(24'h01_0345, 8'hD0);
    check("R9 no erase without 20", 8'(busy), 8'h00);
    do_wr(24'h0, 8'hFF);
    do_wr(24'h0, 8'h20);
    do_wr(24'h01_0345, 8'hD0);
    wait_idle(n);
    check("R10 busy cycles", 8'(n == 256), 8'h01);
    do_rd(24'h01_0300, d); check("R9 block start", d, 8'hFF);
    do_rd(24'h01_03FF, d); check("R9 block end", d, 8'hFF);
    do_rd(24'h01_0400, d); check("R9 above block", d, pat(16'h8400));
    do_rd(24'h01_02FF, d); check("R9 below block", d, pat(16'h82FF));
    do_wr(24'h0, 8'h20);
    do_wr(24'h00_8500, 8'hD0);
    do_wr(24'h0, 8'h70);
    do_rd(24'h00_8500, d); check("R10 read during busy", d, 8'h00);
    wait_idle(n);
    do_rd(24'h00_8501, d); check("R10 write ignored", d, 8'hFF);
  endtask

  task automatic t_chip;
    logic [7:0] d;
    int n;
    @(negedge clk);
    lock_seen = 1'b0;
    hirom_mode = 1'b1;
    do_wr(24'h0, 8'hA7);
    do_wr(24'h00_0000, 8'hD0);
    wait_idle(n);
    check("R11 chip busy cycles", 8'(n == 65536), 8'h01);
    check("R11 locked type no erase", 8'(lock_seen), 8'h00);
    do_rd(24'h00_0000, d); check("R11 first byte", d, 8'hFF);
    do_rd(24'h00_FFFF, d); check("R11 last byte", d, 8'hFF);
    do_rd(24'h00_7777, d); check("R11 mid byte", d, 8'hFF);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = pat(i);
    for (int i = 0; i < (1 << AW2); i++) mem2[i] = 8'(i);
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_fold;
    t_cst;
    t_ext;
    t_id_clr;
    t_prog;
    t_blk;
    t_chip;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule